// File: doc/BRIEF.md
# Transmit FIFO Host Write Interface

This block buffers outgoing packet data between a 32-bit host write port and a byte-wide consumer, such as a transmit serializer. The host presents one double word per cycle of a continuous system clock. The write is taken only while two active-low strobes are both low. Four byte enables say which lanes of the word carry data, and an end-of-frame flag marks the last word of a packet. The stored bytes leave one at a time, and the consumer pulls each one with a pop strobe.

The byte order on the drain side is chosen per word at write time. In little endian mode the lowest lane goes out first. In big endian mode the highest lane goes out first. Lanes whose enables are clear are dropped from the stream. A registered ready flag tells the host that at least a programmable number of double words are free. A write that arrives while all 32 word slots are occupied is discarded and sets a sticky overflow flag.

Top module: `tx_fifo_wr`

## Requirements
- R1: A word is accepted on a rising clock edge only if `wr_cs_n` and `wr_en_n` are both low in that cycle. If either one is high, nothing enters the FIFO and nothing appears on the drain side.
- R2: Byte lane i is `wr_data[8i+7:8i]`, qualified by `wr_be[i]`. When `big_endian` is 0, the enabled lanes of a word are emitted in order starting from lane 0.
- R3: When `big_endian` is 1, the enabled lanes of a word are emitted in order starting from lane 3.
- R4: Lanes whose `wr_be` bit is 0 are skipped and never emitted. A write with all four enables clear is ignored completely.
- R5: `out_last` is 1 together with the final enabled byte of a word that was written with `wr_eof`=1. It is 0 for every other byte.
- R6: The FIFO holds 32 words (128 bytes). A word counts as occupied until its last enabled byte has been popped. A write attempted while 32 words are occupied is dropped, and its bytes are never emitted.
- R7: `overflow` goes to 1 after the edge of a write attempted while the FIFO is full. It stays at 1 until reset.
- R8: `space_ready` is registered. In the cycle after any edge it equals (32 − occupied words) ≥ `space_thresh`, evaluated with the values in place at that edge.
- R9: `out_valid` and `out_byte` hold until `out_pop` is seen high on an edge; that edge advances to the next byte. The first byte of a word written into an empty FIFO is valid after the second rising edge counted from the write edge. Bytes from consecutive stored words follow with no gap.
- R10: While `rst` (synchronous, active high) is 1, the FIFO is emptied, and `space_ready`, `overflow` and `out_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Continuous system clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_cs_n | input | 1 | Active-low transmit interface select |
| wr_en_n | input | 1 | Active-low write enable |
| wr_data | input | 32 | Host write word, four byte lanes |
| wr_be | input | 4 | Per-lane byte enables, bit i qualifies lane i |
| wr_eof | input | 1 | Word is the last of a packet |
| big_endian | input | 1 | 1: emit from lane 3 down, 0: from lane 0 up |
| space_thresh | input | 6 | Free double words required for ready |
| space_ready | output | 1 | Free space is at least the threshold |
| overflow | output | 1 | Sticky flag for a write dropped while full |
| out_byte | output | 8 | Current byte toward the serializer |
| out_valid | output | 1 | `out_byte` holds data |
| out_last | output | 1 | Current byte ends a packet |
| out_pop | input | 1 | Consumer takes the current byte |

## Verification
The assertions assume that `space_thresh` is stable between the edges that sample it. They also assume that `out_pop` has an effect only while `out_valid` is high. The bench changes the threshold only at falling edges and lets a rising edge pass before it checks the ready flag. It raises the pop strobe only after it has seen a valid byte. Every stimulus change happens at a falling edge, so the write strobes, enables and mode bit are steady across each sampling edge.

// File: rtl/txf_pkg.sv
package txf_pkg;
  localparam int BYTE_W = 8;
  localparam int LANES  = 4;
  localparam int DATA_W = BYTE_W * LANES;

  // One stored entry: bytes already in emission order, lane mask, frame end
  typedef struct packed {
    logic              eof;
    logic [LANES-1:0]  mask;
    logic [DATA_W-1:0] data;
  } txf_word_t;

  localparam int WORD_W = $bits(txf_word_t);
endpackage

// File: rtl/txf_lane_order.sv
module txf_lane_order
  import txf_pkg::*;
(
  input  logic [DATA_W-1:0] data_i,
  input  logic [LANES-1:0]  be_i,
  input  logic              eof_i,
  input  logic              big_i,
  output txf_word_t         word_o
);
  // Slot k of the stored word is the k-th byte to leave
  for (genvar k = 0; k < LANES; k++) begin : g_slot
    localparam int SRC_BIG = LANES - 1 - k;
    assign word_o.data[k*BYTE_W +: BYTE_W] = big_i ? data_i[SRC_BIG*BYTE_W +: BYTE_W]
                                                   : data_i[k*BYTE_W +: BYTE_W];
    assign word_o.mask[k] = big_i ? be_i[SRC_BIG] : be_i[k];
  end
  assign word_o.eof = eof_i;
endmodule

// File: rtl/txf_word_mem.sv
module txf_word_mem #(
  parameter int WORDS = 32,
  parameter int W     = 37,
  localparam int AW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/txf_byte_drain.sv
module txf_byte_drain
  import txf_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              avail_i,
  input  logic [WORD_W-1:0] q_i,
  input  logic              pop_i,
  output logic              load_o,
  output logic              fin_o,
  output logic [BYTE_W-1:0] out_byte,
  output logic              out_valid,
  output logic              out_last
);
  localparam int LB = (LANES > 1) ? $clog2(LANES) : 1;

  txf_word_t        qw;
  logic             loaded;
  logic [LANES-1:0] popped;
  logic [LANES-1:0] eff;
  logic [LANES-1:0] sel_bit;
  logic [LB-1:0]    idx;
  logic             single;
  logic             pop_ok;

  assign qw  = q_i;
  assign eff = qw.mask & ~popped & {LANES{loaded}};

  always_comb begin
    idx = '0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (eff[i]) idx = LB'(i);
    end
  end

  assign sel_bit   = LANES'(1) << idx;
  assign single    = (eff != '0) && ((eff & (eff - LANES'(1))) == '0);
  assign out_valid = (eff != '0);
  assign out_byte  = qw.data[idx*BYTE_W +: BYTE_W];
  assign out_last  = qw.eof && single;
  assign pop_ok    = pop_i && out_valid;
  assign fin_o     = pop_ok && single;
  assign load_o    = avail_i && (!out_valid || fin_o);

  always_ff @(posedge clk) begin
    if (rst) begin
      loaded <= 1'b0;
      popped <= '0;
    end else if (load_o) begin
      loaded <= 1'b1;
      popped <= '0;
    end else begin
      if (fin_o) loaded <= 1'b0;
      if (pop_ok) popped <= popped | sel_bit;
    end
  end

  // R9: an unpopped byte stays put
  assert_hold_byte_R9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !pop_i) |=> (out_valid && $stable(out_byte)));

  // R5: a frame end is flagged once per stored word
  assert_last_once_R5: assert property (@(posedge clk) disable iff (rst)
    (out_last && pop_i && !load_o) |=> !out_last);
endmodule

// File: rtl/tx_fifo_wr.sv
module tx_fifo_wr
  import txf_pkg::*;
#(
  parameter int WORDS = 32,
  localparam int AW   = $clog2(WORDS),
  localparam int CW   = $clog2(WORDS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_cs_n,
  input  logic              wr_en_n,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [LANES-1:0]  wr_be,
  input  logic              wr_eof,
  input  logic              big_endian,
  input  logic [CW-1:0]     space_thresh,
  output logic              space_ready,
  output logic              overflow,
  output logic [BYTE_W-1:0] out_byte,
  output logic              out_valid,
  output logic              out_last,
  input  logic              out_pop
);
  txf_word_t         ord;
  logic              wr_hit;
  logic              full;
  logic              push;
  logic              load;
  logic              fin;
  logic [AW:0]       wr_ptr;
  logic [AW:0]       rd_ptr;
  logic [CW-1:0]     occ;
  logic [CW-1:0]     occ_next;
  logic [WORD_W-1:0] q;

  txf_lane_order u_order (
    .data_i (wr_data),
    .be_i   (wr_be),
    .eof_i  (wr_eof),
    .big_i  (big_endian),
    .word_o (ord)
  );

  assign wr_hit = !wr_cs_n && !wr_en_n;
  assign full   = (occ == CW'(WORDS));
  assign push   = wr_hit && !full && (ord.mask != '0);

  txf_word_mem #(.WORDS(WORDS), .W(WORD_W)) u_mem (
    .clk   (clk),
    .we    (push),
    .waddr (wr_ptr[AW-1:0]),
    .wdata (ord),
    .re    (load),
    .raddr (rd_ptr[AW-1:0]),
    .rdata (q)
  );

  txf_byte_drain u_drain (
    .clk       (clk),
    .rst       (rst),
    .avail_i   (wr_ptr != rd_ptr),
    .q_i       (q),
    .pop_i     (out_pop),
    .load_o    (load),
    .fin_o     (fin),
    .out_byte  (out_byte),
    .out_valid (out_valid),
    .out_last  (out_last)
  );

  always_comb begin
    occ_next = occ;
    if (push && !fin) occ_next = occ + CW'(1);
    else if (!push && fin) occ_next = occ - CW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr      <= '0;
      rd_ptr      <= '0;
      occ         <= '0;
      space_ready <= 1'b0;
      overflow    <= 1'b0;
    end else begin
      if (push) wr_ptr <= wr_ptr + (AW+1)'(1);
      if (load) rd_ptr <= rd_ptr + (AW+1)'(1);
      occ         <= occ_next;
      space_ready <= ((CW'(WORDS) - occ_next) >= space_thresh);
      if (wr_hit && full) overflow <= 1'b1;
    end
  end

  // R6: a write into a full FIFO adds no occupancy
  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_hit && full) |=> (occ <= $past(occ)));

  // R6: stored words never exceed the counted occupancy
  assert_mem_count_R6: assert property (@(posedge clk) disable iff (rst)
    ((wr_ptr - rd_ptr) <= (AW+1)'(occ)) && (occ <= CW'(WORDS)));

  // R7: overflow flag is sticky
  assert_overflow_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);

  // R8: ready reflects free space against the sampled threshold
  assert_ready_level_R8: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (space_ready == ((CW'(WORDS) - occ) >= $past(space_thresh))));
endmodule

// File: tb/tx_fifo_wr_tb.sv
module tx_fifo_wr_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_cs_n = 1'b1;
  logic        wr_en_n = 1'b1;
  logic [31:0] wr_data = '0;
  logic [3:0]  wr_be = '0;
  logic        wr_eof = 1'b0;
  logic        big_endian = 1'b0;
  logic [5:0]  space_thresh = 6'd1;
  logic        space_ready;
  logic        overflow;
  logic [7:0]  out_byte;
  logic        out_valid;
  logic        out_last;
  logic        out_pop = 1'b0;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  tx_fifo_wr u_dut (
    .clk(clk), .rst(rst), .wr_cs_n(wr_cs_n), .wr_en_n(wr_en_n),
    .wr_data(wr_data), .wr_be(wr_be), .wr_eof(wr_eof), .big_endian(big_endian),
    .space_thresh(space_thresh), .space_ready(space_ready), .overflow(overflow),
    .out_byte(out_byte), .out_valid(out_valid), .out_last(out_last), .out_pop(out_pop)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d, input logic [3:0] be, input logic eof,
                    input logic big, input logic cs_n, input logic en_n);
    @(negedge clk);
    wr_data = d; wr_be = be; wr_eof = eof; big_endian = big;
    wr_cs_n = cs_n; wr_en_n = en_n;
    @(negedge clk);
    wr_cs_n = 1'b1; wr_en_n = 1'b1;
  endtask

  task automatic get_byte(input string tag, input logic [7:0] eb, input logic el);
    for (int n = 0; n < 6 && !out_valid; n++) @(negedge clk);
    chk({tag, " valid"}, out_valid, 1);
    chk({tag, " byte"}, out_byte, eb);
    chk({tag, " last"}, out_last, el);
    out_pop = 1'b1;
    @(negedge clk);
    out_pop = 1'b0;
  endtask

  task automatic expect_idle(input string tag);
    for (int n = 0; n < 3; n++) @(negedge clk);
    chk(tag, out_valid, 0);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    space_thresh = 6'd1;
    for (int n = 0; n < 3; n++) @(negedge clk);
    chk("R10 valid in reset", out_valid, 0);
    chk("R10 ready in reset", space_ready, 0);
    chk("R10 overflow in reset", overflow, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R8 ready after reset", space_ready, 1);
  endtask

  task automatic t_little();
    wr(32'h44332211, 4'hF, 1'b1, 1'b0, 1'b0, 1'b0);
    get_byte("R2 le b0", 8'h11, 0);
    get_byte("R2 le b1", 8'h22, 0);
    get_byte("R2 le b2", 8'h33, 0);
    get_byte("R5 le b3", 8'h44, 1);
    wr(32'h0D0C0B0A, 4'hF, 1'b0, 1'b0, 1'b0, 1'b0);
    get_byte("R2 noeof b0", 8'h0A, 0);
    get_byte("R2 noeof b1", 8'h0B, 0);
    get_byte("R2 noeof b2", 8'h0C, 0);
    get_byte("R5 noeof b3", 8'h0D, 0);
    expect_idle("R9 empty after drain");
  endtask

  task automatic t_big();
    wr(32'hAABBCCDD, 4'hF, 1'b1, 1'b1, 1'b0, 1'b0);
    get_byte("R3 be b0", 8'hAA, 0);
    get_byte("R3 be b1", 8'hBB, 0);
    get_byte("R3 be b2", 8'hCC, 0);
    get_byte("R3 be b3", 8'hDD, 1);
  endtask

  task automatic t_skip();
    wr(32'h44332211, 4'b0101, 1'b1, 1'b0, 1'b0, 1'b0);
    get_byte("R4 le lane0", 8'h11, 0);
    get_byte("R4 le lane2", 8'h33, 1);
    expect_idle("R4 le nothing more");
    wr(32'h44332211, 4'b0101, 1'b1, 1'b1, 1'b0, 1'b0);
    get_byte("R4 be lane2", 8'h33, 0);
    get_byte("R4 be lane0", 8'h11, 1);
    wr(32'h99887766, 4'b0000, 1'b1, 1'b0, 1'b0, 1'b0);
    expect_idle("R4 zero enables ignored");
  endtask

  task automatic t_gate();
    wr(32'h55555555, 4'hF, 1'b1, 1'b0, 1'b1, 1'b0);
    expect_idle("R1 cs high blocks");
    wr(32'h66666666, 4'hF, 1'b1, 1'b0, 1'b0, 1'b1);
    expect_idle("R1 wr_en high blocks");
    wr(32'h00000077, 4'b0001, 1'b1, 1'b0, 1'b0, 1'b0);
    get_byte("R1 both low writes", 8'h77, 1);
  endtask

  task automatic t_fill();
    @(negedge clk);
    space_thresh = 6'd4;
    for (int k = 0; k < 33; k++) begin
      logic [7:0] b;
      b = 8'(4 * k);
      wr({b + 8'd3, b + 8'd2, b + 8'd1, b}, 4'hF, 1'b1, 1'b0, 1'b0, 1'b0);
      if (k == 26) chk("R8 free 5 ready", space_ready, 1);
      if (k == 27) chk("R8 free 4 ready", space_ready, 1);
      if (k == 28) chk("R8 free 3 not ready", space_ready, 0);
      if (k == 31) chk("R7 no overflow at exact full", overflow, 0);
    end
    chk("R7 overflow after dropped write", overflow, 1);
    space_thresh = 6'd1;
    @(negedge clk);
    chk("R8 full not ready", space_ready, 0);
    for (int i = 0; i < 128; i++) begin
      get_byte("R6 drain", 8'(i), (i % 4) == 3);
    end
    expect_idle("R6 dropped word never emitted");
    chk("R7 overflow still set", overflow, 1);
    chk("R8 ready after drain", space_ready, 1);
  endtask

  initial begin
    t_reset();
    t_little();
    t_big();
    t_skip();
    t_gate();
    t_fill();
    t_reset();
    chk("R10 overflow cleared", overflow, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired, actual running expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule